// File: doc/BRIEF.md
# Serial-Link Command Register with Refresh Watchdog

This block is the decode and supervision stage behind a 16-bit serial register write path. A write that has already been addressed to this register arrives as a one-cycle strobe with its 16-bit word. The low 12 bits carry a command payload, and one further bit carries a loopback value for the host.

The block does three things. First, it copies the loopback bit to an output that the host can read back through the status path. A host that writes a known value and reads the same value back knows that the serial pins work. Second, a dedicated payload triggers a software reset. Third, a second payload acts as the refresh for a link watchdog. When the watchdog is enabled, the host must send that refresh often enough. If it does not, a sticky fault flag rises.

The timeout is a cycle count given on an input. All outputs come from registers.

Top module: `swcmd_ctrl`

## Requirements
- R1: On an accepted write whose payload (bits 11:0) is not 0x555, `link_echo_o` takes the value of data bit 12 from the next cycle on. It holds that value while no write occurs.
- R2: A write with payload 0x555 drives `soft_rst_o` high for exactly the following cycle. The same clock edge clears `link_echo_o` (even when bit 12 is 1), clears `wd_fault_o` and reloads the watchdog counter.
- R3: A write with any payload other than 0x555 or 0x195 produces no reset pulse and does not refresh the watchdog. Only the loopback bit is updated.
- R4: While `wd_enable` is high, a write with payload 0x195 reloads the watchdog counter. Refreshes spaced up to `wd_limit`+1 clock edges apart keep `wd_fault_o` low.
- R5: With `wd_enable` held high and no refresh, `wd_fault_o` rises on the (`wd_limit`+1)-th clock edge after the last reload.
- R6: `wd_fault_o` is sticky. Once high, it stays high through refreshes and through a disable, until a 0x555 write or the hardware reset.
- R7: While `wd_enable` is low, no new fault is raised. A low-to-high transition of `wd_enable` reloads the counter.
- R8: The synchronous active-high `rst` drives `soft_rst_o`, `wd_fault_o` and `link_echo_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle strobe for a write decoded to this register |
| wr_data | input | DATA_W (16) | Write word: payload in bits 11:0, loopback bit in bit 12 |
| wd_enable | input | 1 | Watchdog enable |
| wd_limit | input | CNT_W (16) | Timeout in clock cycles |
| soft_rst_o | output | 1 | One-cycle software reset pulse |
| wd_fault_o | output | 1 | Sticky watchdog fault flag |
| link_echo_o | output | 1 | Loopback bit for status readback |

## Verification
The assertions assume that `wd_limit` stays constant while the watchdog is enabled. They also assume that `wr_en` is only ever a decoded strobe, never an X. The stimulus sets the limit once after reset and never changes it. Refresh spacing is placed exactly at the allowed window edge and one cycle past it, so that both the no-fault and the fault outcome are exercised. Enable transitions, foreign payloads and reset-code writes are driven only on clean cycle boundaries, in the same cycle as the sampled inputs.

// File: rtl/swcmd_pkg.sv
package swcmd_pkg;

  // Kinds of command a write can carry
  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_RESET = 2'd1,
    CMD_KICK  = 2'd2
  } cmd_kind_e;

  // One decoded write
  typedef struct packed {
    logic      valid;
    cmd_kind_e kind;
    logic      user;
  } cmd_t;

endpackage

// File: rtl/swcmd_decode.sv
module swcmd_decode #(
  parameter int          DATA_W     = 16,
  parameter int          CODE_W     = 12,
  parameter int          USER_BIT   = 12,
  parameter logic [11:0] RESET_CODE = 12'h555,
  parameter logic [11:0] KICK_CODE  = 12'h195
) (
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output swcmd_pkg::cmd_t   cmd_o
);
  import swcmd_pkg::*;

  localparam int CW = (CODE_W < 12) ? CODE_W : 12;

  logic [CW-1:0] payload;
  logic          hit_reset;
  logic          hit_kick;

  assign payload = wr_data[CW-1:0];

  // Compare the payload field against both codes
  generate
    if (CW == 12) begin : g_full
      assign hit_reset = (payload == RESET_CODE);
      assign hit_kick  = (payload == KICK_CODE);
    end else begin : g_narrow
      assign hit_reset = (payload == RESET_CODE[CW-1:0]);
      assign hit_kick  = (payload == KICK_CODE[CW-1:0]);
    end
  endgenerate

  always_comb begin
    cmd_o.valid = wr_en;
    cmd_o.user  = wr_data[USER_BIT];
    if (!wr_en)         cmd_o.kind = CMD_NONE;
    else if (hit_reset) cmd_o.kind = CMD_RESET;
    else if (hit_kick)  cmd_o.kind = CMD_KICK;
    else                cmd_o.kind = CMD_NONE;
  end

endmodule

// File: rtl/swcmd_echo.sv
module swcmd_echo (
  input  logic            clk,
  input  logic            rst,
  input  swcmd_pkg::cmd_t cmd_i,
  output logic            echo_o
);
  import swcmd_pkg::*;

  // A reset command clears the bit; any other write loads it
  always_ff @(posedge clk) begin
    if (rst) begin
      echo_o <= 1'b0;
    end else if (cmd_i.valid) begin
      if (cmd_i.kind == CMD_RESET) echo_o <= 1'b0;
      else                         echo_o <= cmd_i.user;
    end
  end

endmodule

// File: rtl/swcmd_rstgen.sv
module swcmd_rstgen (
  input  logic            clk,
  input  logic            rst,
  input  swcmd_pkg::cmd_t cmd_i,
  output logic            pulse_o
);
  import swcmd_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) pulse_o <= 1'b0;
    else     pulse_o <= cmd_i.valid && (cmd_i.kind == CMD_RESET);
  end

endmodule

// File: rtl/swcmd_wdog.sv
module swcmd_wdog #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             clear_i,
  input  logic             kick_i,
  output logic             fault_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             en_q;
  logic             reload;
  logic             expired;

  // A refresh or a rising enable restarts the window
  assign reload  = kick_i || !en_q;
  assign expired = (cnt_q == limit_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      en_q    <= 1'b0;
      fault_o <= 1'b0;
    end else begin
      en_q <= enable_i;
      if (clear_i) begin
        cnt_q   <= '0;
        fault_o <= 1'b0;
      end else if (enable_i) begin
        if (reload)       cnt_q   <= '0;
        else if (expired) fault_o <= 1'b1;
        else              cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/swcmd_ctrl.sv
module swcmd_ctrl #(
  parameter int          DATA_W     = 16,
  parameter int          CODE_W     = 12,
  parameter int          USER_BIT   = 12,
  parameter int          CNT_W      = 16,
  parameter logic [11:0] RESET_CODE = 12'h555,
  parameter logic [11:0] KICK_CODE  = 12'h195
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wd_enable,
  input  logic [CNT_W-1:0]  wd_limit,
  output logic              soft_rst_o,
  output logic              wd_fault_o,
  output logic              link_echo_o
);
  import swcmd_pkg::*;

  cmd_t cmd;
  logic is_reset;
  logic is_kick;

  swcmd_decode #(
    .DATA_W    (DATA_W),
    .CODE_W    (CODE_W),
    .USER_BIT  (USER_BIT),
    .RESET_CODE(RESET_CODE),
    .KICK_CODE (KICK_CODE)
  ) u_decode (
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .cmd_o  (cmd)
  );

  assign is_reset = cmd.valid && (cmd.kind == CMD_RESET);
  assign is_kick  = cmd.valid && (cmd.kind == CMD_KICK);

  swcmd_echo u_echo (
    .clk   (clk),
    .rst   (rst),
    .cmd_i (cmd),
    .echo_o(link_echo_o)
  );

  swcmd_rstgen u_rstgen (
    .clk    (clk),
    .rst    (rst),
    .cmd_i  (cmd),
    .pulse_o(soft_rst_o)
  );

  swcmd_wdog #(.CNT_W(CNT_W)) u_wdog (
    .clk     (clk),
    .rst     (rst),
    .enable_i(wd_enable),
    .limit_i (wd_limit),
    .clear_i (is_reset),
    .kick_i  (is_kick),
    .fault_o (wd_fault_o)
  );

endmodule

// File: rtl/swcmd_ctrl_chk.sv
module swcmd_ctrl_chk #(
  parameter int          DATA_W     = 16,
  parameter int          CODE_W     = 12,
  parameter int          USER_BIT   = 12,
  parameter logic [11:0] RESET_CODE = 12'h555,
  parameter logic [11:0] KICK_CODE  = 12'h195
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              wd_enable,
  input logic              soft_rst_o,
  input logic              wd_fault_o,
  input logic              link_echo_o
);
  logic w_rst;
  logic w_kick;

  assign w_rst  = wr_en && (wr_data[CODE_W-1:0] == RESET_CODE[CODE_W-1:0]);
  assign w_kick = wr_en && (wr_data[CODE_W-1:0] == KICK_CODE[CODE_W-1:0]);

  p_echo_follow_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !w_rst) |=> (link_echo_o == $past(wr_data[USER_BIT])));

  p_echo_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(link_echo_o));

  p_reset_effect_r2: assert property (@(posedge clk) disable iff (rst)
    w_rst |=> (soft_rst_o && !link_echo_o && !wd_fault_o));

  p_pulse_source_r3: assert property (@(posedge clk) disable iff (rst)
    soft_rst_o |-> $past(w_rst));

  p_kick_guard_r4: assert property (@(posedge clk) disable iff (rst)
    (w_kick && wd_enable && !wd_fault_o) |=> !wd_fault_o);

  p_fault_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (wd_fault_o && !w_rst) |=> wd_fault_o);

  p_idle_no_fault_r7: assert property (@(posedge clk) disable iff (rst)
    (!wd_enable && !wd_fault_o) |=> !wd_fault_o);

endmodule

bind swcmd_ctrl swcmd_ctrl_chk #(
  .DATA_W    (DATA_W),
  .CODE_W    (CODE_W),
  .USER_BIT  (USER_BIT),
  .RESET_CODE(RESET_CODE),
  .KICK_CODE (KICK_CODE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .wd_enable  (wd_enable),
  .soft_rst_o (soft_rst_o),
  .wd_fault_o (wd_fault_o),
  .link_echo_o(link_echo_o)
);

// File: tb/swcmd_ctrl_tb.sv
module swcmd_ctrl_tb;
  localparam int LIM = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        wd_enable = 1'b0;
  logic [15:0] wd_limit = 16'(LIM);
  logic        soft_rst_o, wd_fault_o, link_echo_o;

  always #4 clk = ~clk;

  swcmd_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .wd_enable(wd_enable), .wd_limit(wd_limit),
    .soft_rst_o(soft_rst_o), .wd_fault_o(wd_fault_o), .link_echo_o(link_echo_o)
  );

  typedef struct {
    int    due;
    bit    pulse;
    bit    fault;
    bit    echo;
    string req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   done = 0;

  // Reference state built from the requirements
  bit m_echo = 0, m_fault = 0, m_enq = 0;
  int m_cnt = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare the oldest due item away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (soft_rst_o !== e.pulse || wd_fault_o !== e.fault || link_echo_o !== e.echo) begin
        fails++;
        $display("FAIL %s cyc=%0d actual pulse/fault/echo=%b%b%b expected=%b%b%b",
                 e.req, cyc, soft_rst_o, wd_fault_o, link_echo_o, e.pulse, e.fault, e.echo);
      end
    end
  end

  // Driver: apply one cycle of inputs and push the expected outputs
  task automatic step(input bit r, input bit w, input logic [15:0] d,
                      input bit en, input string req);
    exp_t e;
    bit   p;
    bit   isr, isk;
    @(posedge clk);
    #1;
    rst = r; wr_en = w; wr_data = d; wd_enable = en;
    isr = w && (d[11:0] == 12'h555);
    isk = w && (d[11:0] == 12'h195);
    p = 0;
    if (r) begin
      m_echo = 0; m_fault = 0; m_cnt = 0; m_enq = 0;
    end else begin
      p = isr;
      if (isr) begin
        m_echo = 0; m_fault = 0; m_cnt = 0;
      end else begin
        if (w) m_echo = d[12];
        if (en) begin
          if (isk || !m_enq)   m_cnt = 0;
          else if (m_cnt == LIM) m_fault = 1;
          else                 m_cnt++;
        end
      end
      m_enq = en;
    end
    e.due = cyc + 1; e.pulse = p; e.fault = m_fault; e.echo = m_echo; e.req = req;
    q.push_back(e);
  endtask

  task automatic idle(input int n, input bit en, input string req);
    for (int i = 0; i < n; i++) step(0, 0, 16'h0000, en, req);
  endtask

  initial begin
    // R8: reset state
    for (int i = 0; i < 3; i++) step(1, 0, 16'h0000, 0, "R8");
    // R1: loopback bit follows bit 12 and holds
    step(0, 1, 16'h1000, 0, "R1");
    idle(2, 0, "R1");
    step(0, 1, 16'h0000, 0, "R1");
    step(0, 1, 16'h1ABC, 0, "R3");
    idle(1, 0, "R3");
    // R2: reset code with bit 12 set still clears the loopback bit
    step(0, 1, 16'h1555, 0, "R2");
    idle(2, 0, "R2");
    // R4: refresh at the last allowed edge, repeated
    step(0, 0, 16'h0000, 1, "R4");
    for (int k = 0; k < 3; k++) begin
      idle(LIM, 1, "R4");
      step(0, 1, 16'h0195, 1, "R4");
    end
    // R5: one edge late gives the fault
    idle(LIM + 3, 1, "R5");
    // R6: refresh and disable do not clear the fault
    step(0, 1, 16'h1195, 1, "R6");
    idle(3, 0, "R6");
    step(0, 0, 16'h0000, 1, "R6");
    idle(2, 1, "R6");
    // R2: reset code clears the fault
    step(0, 1, 16'h0555, 1, "R2");
    idle(2, 1, "R2");
    // R7: disabled for a long time, no fault; rising enable reloads
    idle(30, 0, "R7");
    idle(LIM + 1, 1, "R7");
    step(0, 1, 16'h0195, 1, "R7");
    // R3: foreign payloads do not refresh
    for (int k = 0; k < 4; k++) begin
      step(0, 1, 16'h0123, 1, "R3");
      idle(1, 1, "R3");
    end
    idle(3, 1, "R3");
    // R8: hardware reset clears a raised fault and the loopback bit
    step(0, 1, 16'h1000, 1, "R8");
    step(1, 0, 16'h0000, 1, "R8");
    idle(2, 0, "R8");
    idle(2, 0, "R8");
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule